// File: doc/BRIEF.md
# Seven-Level Masked Interrupt Priority Unit

This unit sits on the processor side of a prioritized interrupt scheme. External logic presents the highest pending request as a 3-bit level on `req_lvl_i`. Zero means nothing is pending, 1 is the least urgent level and 7 the most urgent. The unit holds a 3-bit interrupt mask, the field a processor keeps in its status word. On every cycle it decides whether the presented level should be serviced.

When a level is taken, the unit does three things in the same cycle. It emits a single-cycle strobe together with the accepted level. It saves the mask it had onto a small last-in-first-out stack. It raises the mask to the accepted level, so that equal and lower levels stay blocked while the handler runs. A return strobe pops the stack and restores the mask saved by the most recent take.

Level 7 cannot be masked. It is taken on its rising transition rather than on its value, so a line held at 7 causes only one take. A new level is believed only after it has been seen on two successive samples, which rejects single-cycle glitches on the encoded lines.

Top module: `irq_prio_unit`

## Requirements
- R1: After synchronous reset, `take_o` is 0, `take_lvl_o` is 0 and `mask_o` is 0.
- R2: A value on `req_lvl_i` is accepted only once it has been sampled equal on two consecutive clock edges. A value present for a single edge is ignored.
- R3: A level from 1 to 6 is taken only when it is strictly greater than `mask_o`. A level equal to or below the mask is never taken, and level 0 is never taken.
- R4: A take drives `take_o` high for one cycle, with `take_lvl_o` equal to the level and `mask_o` equal to that level in the same cycle. `take_lvl_o` is 0 whenever `take_o` is 0. A level first sampled at edge k and held is taken at edge k+2.
- R5: Level 7 is taken on each transition of the accepted level into 7, even when `mask_o` is 7. It is not taken again while the input stays at 7, even if the mask later falls.
- R6: Every take pushes the mask held before it. A high `ret_i` pops the most recent entry into `mask_o`, in last-in-first-out order.
- R7: `ret_i` with an empty save stack leaves `mask_o` unchanged.
- R8: While the save stack holds DEPTH entries (default 4), no take occurs. A transition into level 7 seen while the stack is full is remembered and taken once a return frees an entry.
- R9: In a cycle where `ret_i` is high, no take occurs. A request that is still eligible is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lvl_i | input | 3 | Encoded pending request level, 0 = none |
| ret_i | input | 1 | Handler return strobe, restores the saved mask |
| take_o | output | 1 | Single-cycle interrupt take strobe |
| take_lvl_o | output | 3 | Level being taken, 0 when no take |
| mask_o | output | 3 | Current interrupt mask |

## Verification
The hardest state to reach from the ports is a full save stack with a level-7 transition waiting behind it. Getting there needs four nested takes at strictly rising levels, each held for three edges. A level-7 edge must then arrive while no room is left. The stimulus climbs levels 1 through 4, parks a level 6 request to show that maskable requests are held off, and raises the input to 7. It then issues a single return and checks that the remembered non-maskable take fires on the following edge, not in the return cycle. Separate runs cover a return that collides with an eligible request and a second level-7 edge taken while the mask is already 7.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_IDLE = '0;
    localparam lvl_t LVL_NMI  = '1;

    typedef struct packed {
        logic fire;
        lvl_t lvl;
    } take_t;

    localparam take_t TAKE_NONE = '{fire: 1'b0, lvl: LVL_IDLE};

    // A maskable level wins only when it is non-zero, below the
    // non-maskable level and strictly above the current mask.
    function automatic logic maskable_wins(lvl_t req, lvl_t mask);
        return (req != LVL_IDLE) && (req != LVL_NMI) && (req > mask);
    endfunction

endpackage

// File: rtl/irq_lvl_filter.sv
module irq_lvl_filter
    import irq_prio_pkg::*;
#(
    parameter int SAMPLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t raw_i,
    output lvl_t lvl_o
);

    localparam int HIST = SAMPLES - 1;

    lvl_t hist_q [HIST];
    lvl_t lvl_q;
    logic all_same;

    always_comb begin
        all_same = 1'b1;
        for (int i = 0; i < HIST; i++) begin
            if (hist_q[i] != raw_i) all_same = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= LVL_IDLE;
            lvl_q <= LVL_IDLE;
        end else begin
            hist_q[0] <= raw_i;
            for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
            if (all_same) lvl_q <= raw_i;
        end
    end

    assign lvl_o = lvl_q;

    // R2
    filter_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_o != $past(lvl_o)) |-> ($past(raw_i) == $past(raw_i, 2)));

endmodule

// File: rtl/irq_take_logic.sv
module irq_take_logic
    import irq_prio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvl_t  lvl_i,
    input  lvl_t  mask_i,
    input  logic  full_i,
    input  logic  ret_i,
    output take_t take_o
);

    lvl_t prev_q;
    logic nmi_pend_q;
    logic nmi_edge;
    logic nmi_want;
    logic can_take;
    take_t take_d;

    always_comb begin
        nmi_edge = (lvl_i == LVL_NMI) && (prev_q != LVL_NMI);
        nmi_want = nmi_pend_q || nmi_edge;
        can_take = !full_i && !ret_i;
        take_d   = TAKE_NONE;
        if (can_take) begin
            if (nmi_want) begin
                take_d = '{fire: 1'b1, lvl: LVL_NMI};
            end else if (maskable_wins(lvl_i, mask_i)) begin
                take_d = '{fire: 1'b1, lvl: lvl_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= LVL_IDLE;
            nmi_pend_q <= 1'b0;
        end else begin
            prev_q     <= lvl_i;
            nmi_pend_q <= nmi_want && !can_take;
        end
    end

    assign take_o = take_d;

    // R8
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full_i |-> !take_o.fire);

endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
    import irq_prio_pkg::*;
#(
    parameter int   DEPTH    = 4,
    parameter lvl_t RST_MASK = LVL_IDLE
) (
    input  logic  clk,
    input  logic  rst,
    input  take_t take_i,
    input  logic  ret_i,
    output lvl_t  mask_o,
    output logic  full_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    lvl_t             slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    lvl_t             mask_q;
    logic [CNT_W-1:0] top_cnt;
    logic             empty;

    assign empty   = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign top_cnt = cnt_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= LVL_IDLE;
            cnt_q  <= '0;
            mask_q <= RST_MASK;
        end else if (take_i.fire && !full_o) begin
            slot_q[cnt_q[IDX_W-1:0]] <= mask_q;
            cnt_q  <= cnt_q + CNT_W'(1);
            mask_q <= take_i.lvl;
        end else if (ret_i && !empty) begin
            mask_q <= slot_q[top_cnt[IDX_W-1:0]];
            cnt_q  <= top_cnt;
        end
    end

    assign mask_o = mask_q;

    initial begin
        depth_param_chk: assert (DEPTH >= 2);
    end

    // R7
    empty_ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && empty && !take_i.fire) |=> (mask_o == $past(mask_o)));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_prio_pkg::*;
#(
    parameter int   DEPTH    = 4,
    parameter int   SAMPLES  = 2,
    parameter lvl_t RST_MASK = LVL_IDLE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] req_lvl_i,
    input  logic       ret_i,
    output logic       take_o,
    output logic [2:0] take_lvl_o,
    output logic [2:0] mask_o
);

    lvl_t  lvl_filt;
    lvl_t  mask_cur;
    logic  stack_full;
    take_t take_req;
    take_t take_q;

    irq_lvl_filter #(.SAMPLES(SAMPLES)) filt_i (
        .clk   (clk),
        .rst   (rst),
        .raw_i (req_lvl_i),
        .lvl_o (lvl_filt)
    );

    irq_take_logic take_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_filt),
        .mask_i (mask_cur),
        .full_i (stack_full),
        .ret_i  (ret_i),
        .take_o (take_req)
    );

    irq_mask_stack #(.DEPTH(DEPTH), .RST_MASK(RST_MASK)) stack_i (
        .clk    (clk),
        .rst    (rst),
        .take_i (take_req),
        .ret_i  (ret_i),
        .mask_o (mask_cur),
        .full_o (stack_full)
    );

    always_ff @(posedge clk) begin
        if (rst) take_q <= TAKE_NONE;
        else     take_q <= take_req;
    end

    assign take_o     = take_q.fire;
    assign take_lvl_o = take_q.lvl;
    assign mask_o     = mask_cur;

    // R4
    take_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (mask_o == take_lvl_o));

    // R4
    take_lvl_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (take_lvl_o != 3'd0));

    // R3
    maskable_above_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_lvl_o != 3'd7) |-> (take_lvl_o > $past(mask_o)));

    // R9
    ret_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> !take_o);

endmodule

// File: tb/irq_prio_unit_tb_top.sv
module irq_prio_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_lvl_i = 3'd0;
    logic       ret_i = 1'b0;
    logic       take_o;
    logic [2:0] take_lvl_o;
    logic [2:0] mask_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    irq_prio_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_lvl_i  (req_lvl_i),
        .ret_i      (ret_i),
        .take_o     (take_o),
        .take_lvl_o (take_lvl_o),
        .mask_o     (mask_o)
    );

    // Fields: {in[10:8], ret[7], take[6], take_lvl[5:3], mask[2:0]}
    localparam int NVEC = 28;
    localparam logic [10:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b0, 3'd0, 3'd0},
        {3'd3, 1'b0, 1'b0, 3'd0, 3'd0},
        {3'd3, 1'b0, 1'b0, 3'd0, 3'd0},
        {3'd3, 1'b0, 1'b1, 3'd3, 3'd3},
        {3'd3, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd2, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd2, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd2, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd5, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd2, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd2, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd5, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd5, 1'b0, 1'b0, 3'd0, 3'd3},
        {3'd5, 1'b0, 1'b1, 3'd5, 3'd5},
        {3'd5, 1'b1, 1'b0, 3'd0, 3'd3},
        {3'd5, 1'b0, 1'b1, 3'd5, 3'd5},
        {3'd7, 1'b0, 1'b0, 3'd0, 3'd5},
        {3'd7, 1'b0, 1'b0, 3'd0, 3'd5},
        {3'd7, 1'b0, 1'b1, 3'd7, 3'd7},
        {3'd7, 1'b0, 1'b0, 3'd0, 3'd7},
        {3'd7, 1'b1, 1'b0, 3'd0, 3'd5},
        {3'd7, 1'b0, 1'b0, 3'd0, 3'd5},
        {3'd0, 1'b0, 1'b0, 3'd0, 3'd5},
        {3'd0, 1'b0, 1'b0, 3'd0, 3'd5},
        {3'd0, 1'b1, 1'b0, 3'd0, 3'd3},
        {3'd0, 1'b1, 1'b0, 3'd0, 3'd0},
        {3'd0, 1'b1, 1'b0, 3'd0, 3'd0},
        {3'd0, 1'b0, 1'b0, 3'd0, 3'd0}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_lvl_i = 3'd0;
        ret_i = 1'b0;
        tick();
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic check(input string tag, input logic t, input logic [2:0] tl,
                         input logic [2:0] m);
        n_run++;
        if (take_o !== t || take_lvl_o !== tl || mask_o !== m) begin
            n_fail++;
            $display("FAIL %s: take/lvl/mask actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     tag, take_o, take_lvl_o, mask_o, t, tl, m);
        end
    endtask

    // Drive a level and tick until a take; expect it on the third edge.
    task automatic climb(input string tag, input logic [2:0] lvl);
        int hit = 0;
        req_lvl_i = lvl;
        for (int k = 1; k <= 5; k++) begin
            tick();
            if (take_o && hit == 0) hit = k;
        end
        n_run++;
        if (hit != 3 || mask_o !== lvl) begin
            n_fail++;
            $display("FAIL %s: take edge/mask actual %0d/%0d expected 3/%0d",
                     tag, hit, mask_o, lvl);
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 reset", 1'b0, 3'd0, 3'd0);

        // Table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            req_lvl_i = VEC[i][10:8];
            ret_i     = VEC[i][7];
            tick();
            check($sformatf("table row %0d (R2 R3 R4 R5 R6 R7)", i),
                  VEC[i][6], VEC[i][5:3], VEC[i][2:0]);
        end
        ret_i = 1'b0;

        // R9: return collides with an eligible request
        do_reset();
        req_lvl_i = 3'd2;
        tick();
        tick();
        ret_i = 1'b1;
        tick();
        check("R9 no take in return cycle", 1'b0, 3'd0, 3'd0);
        ret_i = 1'b0;
        tick();
        check("R9 take on next edge", 1'b1, 3'd2, 3'd2);

        // R8: fill the stack, hold off takes, remember a level 7 edge
        do_reset();
        climb("R8 nest level 1", 3'd1);
        climb("R8 nest level 2", 3'd2);
        climb("R8 nest level 3", 3'd3);
        climb("R8 nest level 4", 3'd4);
        req_lvl_i = 3'd6;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R8 maskable held while full", 1'b0, 3'd0, 3'd4);
        end
        req_lvl_i = 3'd7;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R8 level 7 held while full", 1'b0, 3'd0, 3'd4);
        end
        ret_i = 1'b1;
        tick();
        check("R8 return frees entry", 1'b0, 3'd0, 3'd3);
        ret_i = 1'b0;
        tick();
        check("R8 remembered level 7 taken", 1'b1, 3'd7, 3'd7);
        tick();
        check("R5 no retake after remembered take", 1'b0, 3'd0, 3'd7);

        // R5: second edge into 7 while the mask is already 7
        do_reset();
        climb("R5 first level 7", 3'd7);
        req_lvl_i = 3'd6;
        tick();
        tick();
        check("R5 level 6 blocked by mask 7", 1'b0, 3'd0, 3'd7);
        req_lvl_i = 3'd7;
        tick();
        tick();
        tick();
        check("R5 level 7 retaken on new edge", 1'b1, 3'd7, 3'd7);
        // R6: two pops return 7 then 0
        ret_i = 1'b1;
        tick();
        check("R6 first pop", 1'b0, 3'd0, 3'd7);
        tick();
        check("R6 second pop", 1'b0, 3'd0, 3'd0);
        ret_i = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule